// File: doc/BRIEF.md
# I2S to Dual-Converter Serial Aligner

This block takes a stereo I2S stream of 16-bit two's-complement samples and turns it into two serial lines, one per channel, for a pair of right-justified 20-bit or 24-bit converters. The two converters share one load strobe and so update on the same edge. Everything runs on the incoming bit clock.

The left word arrives one slot before the right word. The block delays it by one full 32-cycle slot, so both words leave together during the right-channel slot. Both lines are then delayed again by a few cycles, so that each sample's MSB sits in the MSB position of the converter word. The converter word ends on the last rising edge before the load strobe falls. That extra delay is `32 - DAC_BITS - 1` cycles: 7 cycles for a 24-bit target and 11 cycles for a 20-bit target.

The word-select input is passed to the load strobe unchanged. Each data output comes from a flop clocked on the falling edge of the bit clock. As a result the data changes half a cycle away from the edge on which the converter samples it.

Top module: `i2s_dac_aligner`

## Requirements
- R1: While `rst_n` is low at a rising edge, every delay stage clears, and both data outputs are 0 by the following falling edge. After release, `dac_right` stays 0 for the first XD rising edges and `dac_left` for the first 32+XD, where XD = 32 - DAC_BITS - 1.
- R2: In each right slot (`word_sel` high, rising edges 0..31 counted from the first edge with `word_sel` high), the value `dac_right` holds at edge m, for m >= XD, equals the `ser_in` value at edge m-XD of that same slot.
- R3: In that right slot, `dac_left` at edge m, for m >= XD, equals the `ser_in` value at edge m-XD of the preceding left slot (`word_sel` low). Both channels therefore carry the same bit position on the same edge.
- R4: For a 16-bit sample, the sample MSB (which is on slot edge 1) appears on both outputs at right-slot edge XD+1. The converter-word LSB position, right-slot edge 31, carries slot edge 31-XD. With the default DAC_BITS=24, this places the MSB at edge 8 and puts slot bit 24 at edge 31.
- R5: `dac_load` equals `word_sel` at all times, with no delay.
- R6: The data outputs change only at falling edges. The value seen just before a rising edge equals the value seen just after it.
- R7: Slot bits after the 16th pass through the same delay unchanged. A 24-bit input word on slot edges 1..24 fills edges XD+1..31 exactly.
- R8: Reset applied in the middle of a stream discards all stored data and gives the same output behaviour as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset |
| word_sel | input | 1 | Channel select: low for left, high for right |
| ser_in | input | 1 | I2S serial data, MSB one cycle after a channel change |
| dac_left | output | 1 | Right-justified serial data for the left converter |
| dac_right | output | 1 | Right-justified serial data for the right converter |
| dac_load | output | 1 | Shared load strobe for both converters |

## Verification
Both channels share one delay chain. A stuck or mis-shifted stage therefore shows up as wrong bits on `dac_right` within XD cycles, or on `dac_left` within one slot plus XD cycles, at a fixed bit position of every frame. A tap taken one stage off moves the whole sample by one bit, which scales the converter output by two; comparing every bit of the right slot against the expected one catches this in the first checked frame. A retiming flop that updates on the wrong edge appears as a value that differs across the sampling edge.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
    // Cycles in one channel slot of the incoming stream
    localparam int SLOT_CYCLES = 32;
    // Cycles between a channel change and the sample MSB
    localparam int MSB_LEAD = 1;

    // Extra cycles that put the sample MSB at the converter-word MSB position
    function automatic int extra_delay(input int dac_bits);
        return SLOT_CYCLES - dac_bits - MSB_LEAD;
    endfunction
endpackage

// File: rtl/dly_chain.sv
// Serial shift chain on the rising bit-clock edge.
// Provides two taps: a short one after TAP stages and the chain end after LEN stages.
// Assumes 1 <= TAP < LEN.
module dly_chain #(
    parameter int LEN = 39,
    parameter int TAP = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic tap_short,
    output logic tap_end
);
    logic [LEN-1:0] stage_q;

    // Shift one bit per rising edge; reset clears every stage
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[LEN-2:0], din};
    end

    assign tap_short = stage_q[TAP-1];
    assign tap_end   = stage_q[LEN-1];

    AST_CHAIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stage_q == '0)); // R1
endmodule

// File: rtl/retime_half.sv
// Adds a half-cycle step: with HALF_STEP=1, a falling-edge flop re-times the
// bit so that it changes away from the converter's sampling edge.
// With HALF_STEP=0 the bit passes straight through.
module retime_half #(
    parameter bit HALF_STEP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (HALF_STEP) begin : g_neg
            logic q;

            // Capture on the falling edge; reset clears it
            always_ff @(negedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= din;
            end

            assign dout = q;

            AST_HALF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (q == 1'b0)); // R1
        end else begin : g_thru
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/i2s_dac_aligner.sv
// Aligns an I2S stereo stream to two right-justified converter lines sharing
// one load strobe. The left word is delayed by one slot. Both words get XD
// extra cycles so their MSB sits at the converter-word MSB position.
// Assumes a 32-cycle slot with the MSB one cycle after each channel change,
// and DAC_BITS of 20 or 24.
module i2s_dac_aligner #(
    parameter int DAC_BITS = 24
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic word_sel,
    input  logic ser_in,
    output logic dac_left,
    output logic dac_right,
    output logic dac_load
);
    import aligner_pkg::*;

    localparam int XD      = extra_delay(DAC_BITS);
    localparam int CHAIN   = SLOT_CYCLES + XD;
    localparam int WARM_W  = $clog2(CHAIN + 2);
    localparam logic [WARM_W-1:0] WARM_MAX = '1;

    logic [1:0] tap;   // [0] right channel, [1] left channel
    logic [1:0] line;

    dly_chain #(.LEN(CHAIN), .TAP(XD)) u_chain (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .din       (ser_in),
        .tap_short (tap[0]),
        .tap_end   (tap[1])
    );

    generate
        for (genvar ch = 0; ch < 2; ch++) begin : g_ch
            retime_half #(.HALF_STEP(1'b1)) u_half (
                .clk   (bit_clk),
                .rst_n (rst_n),
                .din   (tap[ch]),
                .dout  (line[ch])
            );
        end
    endgenerate

    assign dac_right = line[0];
    assign dac_left  = line[1];
    assign dac_load  = word_sel;

    // Cycles since reset release, saturating; qualifies the delay checks
    logic [WARM_W-1:0] warm_q;
    always_ff @(posedge bit_clk) begin
        if (!rst_n)                 warm_q <= '0;
        else if (warm_q != WARM_MAX) warm_q <= warm_q + 1'b1;
    end

    AST_RIGHT_DELAY: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (int'(warm_q) >= XD) |-> (dac_right == $past(ser_in, XD))); // R2
    AST_LEFT_LAGS_SLOT: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (int'(warm_q) >= CHAIN) |-> (dac_left == $past(dac_right, SLOT_CYCLES))); // R3
    AST_RIGHT_QUIET_AFTER_RESET: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (int'(warm_q) < XD) |-> (dac_right == 1'b0)); // R8
endmodule

// File: tb/sim_i2s_dac_aligner.sv
module sim_i2s_dac_aligner;
    localparam int DACW = 24;
    localparam int XD   = 32 - DACW - 1;

    logic bit_clk  = 1'b0;
    logic rst_n    = 1'b0;
    logic word_sel = 1'b0;
    logic ser_in   = 1'b0;
    logic dac_left, dac_right, dac_load;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic pre_l, pre_r, pre_ld, post_l, post_r;

    always #2 bit_clk = ~bit_clk;

    i2s_dac_aligner #(.DAC_BITS(DACW)) u0 (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .word_sel(word_sel),
        .ser_in  (ser_in),
        .dac_left(dac_left),
        .dac_right(dac_right),
        .dac_load(dac_load)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive one edge's inputs (called at rising edge + 1 ns), sample before and after that edge
    task automatic edge_step(input logic ws, input logic sd);
        word_sel = ws;
        ser_in   = sd;
        #2;
        pre_l  = dac_left;
        pre_r  = dac_right;
        pre_ld = dac_load;
        check("R5", "load follows select", pre_ld, ws);
        @(posedge bit_clk);
        #1;
        post_l = dac_left;
        post_r = dac_right;
    endtask

    function automatic logic [31:0] slot16(input logic [15:0] s);
        logic [31:0] v = '0;
        for (int i = 0; i < 16; i++) v[1+i] = s[15-i];
        return v;
    endfunction

    function automatic logic [31:0] slot24(input logic [23:0] s);
        logic [31:0] v = '0;
        for (int i = 0; i < 24; i++) v[1+i] = s[23-i];
        return v;
    endfunction

    // Reset with data high, then check the outputs stay clear after release (R1 / R8)
    task automatic reset_scenario(input string req);
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            edge_step(k[0], 1'b1);
            check(req, "right in reset", pre_r, 1'b0);
            check(req, "left in reset", pre_l, 1'b0);
        end
        rst_n = 1'b1;
        for (int k = 0; k < 32; k++) begin
            edge_step(1'b0, 1'b1);
            check(req, $sformatf("right k=%0d after release", k), pre_r, (k >= XD) ? 1'b1 : 1'b0);
            check(req, $sformatf("left k=%0d after release", k), pre_l, 1'b0);
        end
    endtask

    // Send one left slot and one right slot, then check both lines during the right slot
    task automatic frame_scenario(input logic [31:0] ls, input logic [31:0] rs, input bit wide, input string name);
        for (int e = 0; e < 32; e++) edge_step(1'b0, ls[e]);
        for (int m = 0; m < 32; m++) begin
            edge_step(1'b1, rs[m]);
            if (m >= XD) begin
                string rq;
                rq = (wide && (m > 16 + XD)) ? "R7" : "R2";
                check(rq, $sformatf("%s right m=%0d", name, m), pre_r, rs[m-XD]);
                rq = (wide && (m > 16 + XD)) ? "R7" : "R3";
                check(rq, $sformatf("%s left m=%0d", name, m), pre_l, ls[m-XD]);
                check("R6", $sformatf("%s right across edge m=%0d", name, m), post_r, pre_r);
                check("R6", $sformatf("%s left across edge m=%0d", name, m), post_l, pre_l);
            end
            if (m == XD + 1) begin
                check("R4", $sformatf("%s right MSB", name), pre_r, rs[1]);
                check("R4", $sformatf("%s left MSB", name), pre_l, ls[1]);
            end
            if (m == 31) begin
                check("R4", $sformatf("%s right word end", name), pre_r, rs[31-XD]);
                check("R4", $sformatf("%s left word end", name), pre_l, ls[31-XD]);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(posedge bit_clk);
        #1;
        reset_scenario("R1");
        frame_scenario(slot16(16'h8001), slot16(16'h7FFE), 1'b0, "extremes");
        frame_scenario(slot16(16'hA5C3), slot16(16'h3C5A), 1'b0, "mixed");
        frame_scenario(slot16(16'h0000), slot16(16'hFFFF), 1'b0, "flat");
        frame_scenario(slot24(24'h123456), slot24(24'hFEDCBB), 1'b1, "wide");
        reset_scenario("R8");
        frame_scenario(slot16(16'h4B2D), slot16(16'hC0F1), 1'b0, "post-reset");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule